// File: doc/BRIEF.md
# Atomic Access Attribute Checker

This block checks each atomic memory request against the attributes of the address region that the request targets. It answers with either a grant or an access fault. A table of eight regions is loaded through a plain write port. Each region holds a base address, a byte size, an AMO support tier, a reservability tier for load-reserved/store-conditional, and two bitmasks that list the access widths the region can read and write.

A request carries an address, a size code and an operation class: LR, SC, or one of the AMO operations. The registered response appears on the clock edge after the request. A grant of LR or SC in a region that is reservable but gives no eventual-success guarantee also raises a flag, so software can take a fall-back path. The block does not execute the operation, track reservations or take part in coherence.

Top module: `atomAttrChecker`

## Requirements
- R1: The response for a request presented in cycle N appears in cycle N+1 with rspValid high. In a cycle after no request, rspValid, rspGrant, rspFault and rspNoEventual are all low.
- R2: A request whose address lies in no enabled region faults. A region matches when base <= addr < base+size. A region with size 0 is disabled, and reset disables every region.
- R3: When enabled regions overlap, the attributes of the lowest-indexed matching region decide the response.
- R4: The AMO tier is a 2-bit code. Code 0 faults every AMO. Code 1 grants only SWAP. Code 2 grants SWAP, AND, OR and XOR. Code 3 grants every AMO. The op codes are 0=LR, 1=SC, 2=SWAP, 3=ADD, 4=AND, 5=OR, 6=XOR, 7=MIN, 8=MAX, 9=MINU, 10=MAXU.
- R5: The reservability tier is a 2-bit code. Codes 0 and 3 fault both LR and SC. Code 1 (no guarantee) and code 2 (guaranteed) grant both.
- R6: rspNoEventual is high exactly when an LR or SC is granted in a region with reservability code 1.
- R7: A size code w (bytes = 1<<w, w=0..3) is allowed only when bit w is set in both the read mask and the write mask of the region. Otherwise the request faults.
- R8: A request whose address is not a multiple of its byte size faults.
- R9: A table write in cycle N takes effect for requests presented in cycle N+1 and later. A request presented in cycle N still sees the old entry.
- R10: Op codes 11 to 15 always fault.
- R11: Whenever rspValid is high, exactly one of rspGrant and rspFault is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Write one region entry |
| cfgWrIdx | input | 3 | Index of the entry to write |
| cfgBase | input | 32 | Region base address |
| cfgSize | input | 32 | Region size in bytes, 0 disables the entry |
| cfgAmoLvl | input | 2 | AMO tier code |
| cfgRsrvLvl | input | 2 | Reservability tier code |
| cfgRdWidths | input | 4 | Readable widths, bit w stands for 1<<w bytes |
| cfgWrWidths | input | 4 | Writable widths, bit w stands for 1<<w bytes |
| reqValid | input | 1 | Request present |
| reqAddr | input | 32 | Request address |
| reqWidth | input | 2 | Size code, bytes = 1<<reqWidth |
| reqOp | input | 4 | Operation class code |
| rspValid | output | 1 | Response present |
| rspGrant | output | 1 | Request allowed |
| rspFault | output | 1 | Request faults |
| rspNoEventual | output | 1 | Granted LR/SC has no eventual-success guarantee |

## Verification
A corrupted region entry does not fail loudly. It shows up as a wrong grant or fault, and only on the first request that lands in that region, one cycle after that request. The bench therefore probes every region with requests that sit on both sides of each tier threshold. A wrong priority choice shows only at addresses where regions overlap, so those addresses are probed on purpose. Write timing is checked by sending a request in the same cycle as the write and again in the cycle after it.

// File: rtl/atomAttrPkg.sv
package atomAttrPkg;
  localparam int ADDR_W      = 32;
  localparam int NUM_WIDTHS  = 4;
  localparam int NUM_REGIONS = 8;
  localparam int IDX_W       = $clog2(NUM_REGIONS);
  localparam int SZ_W        = $clog2(NUM_WIDTHS);

  localparam logic [3:0] OP_LR   = 4'd0;
  localparam logic [3:0] OP_SC   = 4'd1;
  localparam logic [3:0] OP_SWAP = 4'd2;
  localparam logic [3:0] OP_ADD  = 4'd3;
  localparam logic [3:0] OP_AND  = 4'd4;
  localparam logic [3:0] OP_OR   = 4'd5;
  localparam logic [3:0] OP_XOR  = 4'd6;
  localparam logic [3:0] OP_MAXU = 4'd10;

  typedef struct packed {
    logic [ADDR_W-1:0]     base;
    logic [ADDR_W-1:0]     size;
    logic [1:0]            amoLvl;
    logic [1:0]            rsrvLvl;
    logic [NUM_WIDTHS-1:0] rdWidths;
    logic [NUM_WIDTHS-1:0] wrWidths;
  } regionT;

  // strobes from control to the table datapath
  typedef struct packed {
    logic [NUM_REGIONS-1:0] entryWr;
    logic                   lookupEn;
  } ctrlStrobeT;
endpackage

// File: rtl/atomAttrTable.sv
module atomAttrTable
  import atomAttrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  regionT            wrEntry,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              hit,
  output regionT            hitAttr
);
  regionT                 entries [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] matchVec;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN)                   entries[i] <= '0;
      else if (strobe.entryWr[i])  entries[i] <= wrEntry;
    end
    assign matchVec[i] = (entries[i].size != '0) &&
                         (lookupAddr >= entries[i].base) &&
                         ((lookupAddr - entries[i].base) < entries[i].size);
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    hit     = 1'b0;
    hitAttr = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (matchVec[i] && strobe.lookupEn) begin
        hit     = 1'b1;
        hitAttr = entries[i];
      end
    end
  end

  // R9: at most one entry is written per cycle
  assert_single_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.entryWr));
  // R2: a hit needs an enabled lookup
  assert_hit_needs_lookup_R2: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> strobe.lookupEn);
endmodule

// File: rtl/atomAttrCtrl.sv
module atomAttrCtrl
  import atomAttrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [IDX_W-1:0]  cfgWrIdx,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SZ_W-1:0]   reqWidth,
  input  logic [3:0]        reqOp,
  input  logic              hit,
  input  regionT            hitAttr,
  output ctrlStrobeT        strobe,
  output logic              rspValid,
  output logic              rspGrant,
  output logic              rspFault,
  output logic              rspNoEventual
);
  logic [ADDR_W-1:0] lowMask;
  logic misaligned, widthOk, isRsrv, rsrvOk, amoOk, allowNow, noEvNow;

  always_comb begin
    strobe.entryWr = '0;
    if (cfgWrEn) strobe.entryWr[cfgWrIdx] = 1'b1;
    strobe.lookupEn = reqValid;
  end

  assign lowMask    = (ADDR_W'(1) << reqWidth) - ADDR_W'(1);
  assign misaligned = |(reqAddr & lowMask);
  assign widthOk    = hitAttr.rdWidths[reqWidth] && hitAttr.wrWidths[reqWidth];
  assign isRsrv     = (reqOp == OP_LR) || (reqOp == OP_SC);
  assign rsrvOk     = (hitAttr.rsrvLvl == 2'd1) || (hitAttr.rsrvLvl == 2'd2);

  always_comb begin
    if (reqOp == OP_SWAP)
      amoOk = hitAttr.amoLvl >= 2'd1;
    else if (reqOp == OP_AND || reqOp == OP_OR || reqOp == OP_XOR)
      amoOk = hitAttr.amoLvl >= 2'd2;
    else if (reqOp == OP_ADD || (reqOp >= 4'd7 && reqOp <= OP_MAXU))
      amoOk = hitAttr.amoLvl == 2'd3;
    else
      amoOk = 1'b0;
  end

  assign allowNow = hit && !misaligned && widthOk && (isRsrv ? rsrvOk : amoOk);
  assign noEvNow  = allowNow && isRsrv && (hitAttr.rsrvLvl == 2'd1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid      <= 1'b0;
      rspGrant      <= 1'b0;
      rspFault      <= 1'b0;
      rspNoEventual <= 1'b0;
    end else begin
      rspValid      <= reqValid;
      rspGrant      <= reqValid && allowNow;
      rspFault      <= reqValid && !allowNow;
      rspNoEventual <= reqValid && noEvNow;
    end
  end

  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !(rspGrant || rspFault || rspNoEventual));
  assert_grant_xor_fault_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspGrant != rspFault));
  assert_noev_implies_grant_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspNoEventual |-> rspGrant);
  assert_misaligned_faults_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && misaligned) |=> rspFault);
endmodule

// File: rtl/atomAttrChecker.sv
module atomAttrChecker
  import atomAttrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [IDX_W-1:0]  cfgWrIdx,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgSize,
  input  logic [1:0]        cfgAmoLvl,
  input  logic [1:0]        cfgRsrvLvl,
  input  logic [NUM_WIDTHS-1:0] cfgRdWidths,
  input  logic [NUM_WIDTHS-1:0] cfgWrWidths,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SZ_W-1:0]   reqWidth,
  input  logic [3:0]        reqOp,
  output logic              rspValid,
  output logic              rspGrant,
  output logic              rspFault,
  output logic              rspNoEventual
);
  ctrlStrobeT strobe;
  regionT     wrEntry;
  regionT     hitAttr;
  logic       hit;

  assign wrEntry = '{base: cfgBase, size: cfgSize, amoLvl: cfgAmoLvl,
                     rsrvLvl: cfgRsrvLvl, rdWidths: cfgRdWidths,
                     wrWidths: cfgWrWidths};

  atomAttrTable uTable (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEntry(wrEntry),
    .lookupAddr(reqAddr), .hit(hit), .hitAttr(hitAttr)
  );

  atomAttrCtrl uCtrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqWidth(reqWidth), .reqOp(reqOp),
    .hit(hit), .hitAttr(hitAttr), .strobe(strobe),
    .rspValid(rspValid), .rspGrant(rspGrant), .rspFault(rspFault),
    .rspNoEventual(rspNoEventual)
  );
endmodule

// File: tb/sim_atomAttrChecker.sv
module sim_atomAttrChecker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgWrIdx = '0;
  logic [31:0] cfgBase = '0, cfgSize = '0;
  logic [1:0]  cfgAmoLvl = '0, cfgRsrvLvl = '0;
  logic [3:0]  cfgRdWidths = '0, cfgWrWidths = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqWidth = '0;
  logic [3:0]  reqOp = '0;
  logic        rspValid, rspGrant, rspFault, rspNoEventual;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  atomAttrChecker u0 (.*);

  // {addr, width, op, expGrant, expNoEventual, reqTag}
  localparam int NV = 21;
  localparam logic [43:0] VEC [NV] = '{
    {32'h1000, 2'd2, 4'd3,  1'b1, 1'b0, 4'd4},  // R4 tier 3 ADD
    {32'h1008, 2'd3, 4'd10, 1'b1, 1'b0, 4'd4},  // R4 tier 3 MAXU
    {32'h1000, 2'd2, 4'd0,  1'b1, 1'b0, 4'd5},  // R5 guaranteed LR
    {32'h2000, 2'd2, 4'd3,  1'b0, 1'b0, 4'd4},  // R4 tier 2 ADD faults
    {32'h2004, 2'd2, 4'd6,  1'b1, 1'b0, 4'd4},  // R4 tier 2 XOR
    {32'h2008, 2'd3, 4'd2,  1'b1, 1'b0, 4'd4},  // R4 tier 2 SWAP
    {32'h2000, 2'd2, 4'd0,  1'b1, 1'b1, 4'd6},  // R6 LR no guarantee
    {32'h2000, 2'd2, 4'd1,  1'b1, 1'b1, 4'd6},  // R6 SC no guarantee
    {32'h3000, 2'd2, 4'd2,  1'b1, 1'b0, 4'd4},  // R4 tier 1 SWAP
    {32'h3000, 2'd2, 4'd4,  1'b0, 1'b0, 4'd4},  // R4 tier 1 AND faults
    {32'h3000, 2'd2, 4'd0,  1'b0, 1'b0, 4'd5},  // R5 code 0 LR faults
    {32'h3000, 2'd3, 4'd2,  1'b0, 1'b0, 4'd7},  // R7 no 8-byte write
    {32'h3002, 2'd1, 4'd2,  1'b1, 1'b0, 4'd7},  // R7 halfword allowed
    {32'h4000, 2'd2, 4'd2,  1'b0, 1'b0, 4'd4},  // R4 tier 0 SWAP faults
    {32'h4000, 2'd2, 4'd1,  1'b0, 1'b0, 4'd5},  // R5 code 3 SC faults
    {32'h1084, 2'd2, 4'd3,  1'b1, 1'b0, 4'd3},  // R3 overlap, entry 0 wins
    {32'h1104, 2'd2, 4'd3,  1'b0, 1'b0, 4'd3},  // R3 only entry 4 matches
    {32'h1002, 2'd2, 4'd3,  1'b0, 1'b0, 4'd8},  // R8 misaligned word
    {32'h1001, 2'd0, 4'd3,  1'b1, 1'b0, 4'd8},  // R8 byte always aligned
    {32'h5000, 2'd2, 4'd2,  1'b0, 1'b0, 4'd2},  // R2 no region
    {32'h1000, 2'd2, 4'd12, 1'b0, 1'b0, 4'd10}  // R10 reserved op
  };

  task automatic wrRegion(input int idx, input logic [31:0] b, input logic [31:0] s,
                          input logic [1:0] amo, input logic [1:0] rsv,
                          input logic [3:0] rd, input logic [3:0] wr);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrIdx = 3'(idx); cfgBase = b; cfgSize = s;
    cfgAmoLvl = amo; cfgRsrvLvl = rsv; cfgRdWidths = rd; cfgWrWidths = wr;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic expectRsp(input string tag, input logic v, input logic g,
                           input logic f, input logic ne);
    checks++;
    if ({rspValid, rspGrant, rspFault, rspNoEventual} !== {v, g, f, ne}) begin
      errors++;
      $display("FAIL %s: got v/g/f/ne=%b%b%b%b expected %b%b%b%b", tag,
               rspValid, rspGrant, rspFault, rspNoEventual, v, g, f, ne);
    end
  endtask

  // presents one request and samples the response one cycle later
  task automatic request(input logic [31:0] a, input logic [1:0] w, input logic [3:0] op);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWidth = w; reqOp = op;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expectRsp("R1 reset state", 0, 0, 0, 0);
    request(32'h1000, 2'd2, 4'd2);
    expectRsp("R2 empty table after reset", 1, 0, 1, 0);

    wrRegion(0, 32'h1000, 32'h100, 2'd3, 2'd2, 4'hF, 4'hF);
    wrRegion(1, 32'h2000, 32'h100, 2'd2, 2'd1, 4'hF, 4'hF);
    wrRegion(2, 32'h3000, 32'h100, 2'd1, 2'd0, 4'hF, 4'h7);
    wrRegion(3, 32'h4000, 32'h100, 2'd0, 2'd3, 4'hF, 4'hF);
    wrRegion(4, 32'h1080, 32'h100, 2'd0, 2'd0, 4'hF, 4'hF);

    for (int i = 0; i < NV; i++) begin
      logic [43:0] vv;
      vv = VEC[i];
      request(vv[43:12], vv[11:10], vv[9:6]);
      // R11 exactly one of grant/fault; R1 valid one cycle later
      expectRsp($sformatf("R%0d vector %0d", vv[3:0], i), 1, vv[5], !vv[5], vv[4]);
    end

    @(negedge clk);
    expectRsp("R1 idle cycle", 0, 0, 0, 0);

    // R9: request in the same cycle as the write sees the old (empty) entry
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrIdx = 3'd5; cfgBase = 32'h6000; cfgSize = 32'h100;
    cfgAmoLvl = 2'd3; cfgRsrvLvl = 2'd2; cfgRdWidths = 4'hF; cfgWrWidths = 4'hF;
    reqValid = 1'b1; reqAddr = 32'h6000; reqWidth = 2'd2; reqOp = 4'd2;
    @(negedge clk);
    cfgWrEn = 1'b0;
    expectRsp("R9 same-cycle write not seen", 1, 0, 1, 0);
    @(negedge clk);
    reqValid = 1'b0;
    expectRsp("R9 next-cycle write seen", 1, 1, 0, 0);

    // R2: size zero disables the entry
    wrRegion(5, 32'h6000, 32'h0, 2'd3, 2'd2, 4'hF, 4'hF);
    request(32'h6000, 2'd2, 4'd2);
    expectRsp("R2 size zero disabled", 1, 0, 1, 0);

    // R2: last byte inside region 0, first byte past region 4
    request(32'h10FF, 2'd0, 4'd3);
    expectRsp("R2 upper edge inside", 1, 1, 0, 0);
    request(32'h1180, 2'd0, 4'd2);
    expectRsp("R2 just past end", 1, 0, 1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule